// File: doc/BRIEF.md
# Sequenced ROM Accumulator

This unit adds up the words of a small constant table and reports the total through a start/done handshake. The table is a read-only lookup with one address input and one data output. Its entries are the smallest primes in increasing order: address 0 holds 2, address 1 holds 3, and so on. The default table has eight 16-bit entries, so it holds 2, 3, 5, 7, 11, 13, 17 and 19, which total 77. All values are treated as two's-complement signed numbers, and the adder wraps modulo 2^16.

The design has two parts. A controller holds the state register, the address counter and the next-state logic. A datapath holds the table, the adder and the accumulator register, which has clear and add controls. While idle, the unit waits for `start` to be sampled high on a rising clock edge. It then reads one table entry per cycle into the accumulator. Eight cycles after the accepting edge it raises `done` for a single cycle, and shows the total on `sum` during that cycle only. After that cycle it returns to idle by itself.

Top module: `seq_rom_accum`

## Requirements
- R1: A clock edge with `rst` high clears the unit. From the next cycle `done` is 0 and `sum` is 0.
- R2: While idle with `start` low, `done` stays 0 indefinitely.
- R3: When `start` is sampled high in idle, `done` is 1 in exactly the cycle that follows the 8th rising edge after the accepting edge.
- R4: While `done` is 1, `sum` equals the 16-bit wrapped sum of the table entries. The table holds the k-th smallest prime at address k (2, 3, 5, 7, 11, 13, 17, 19), so the sum is 77.
- R5: `done` is high for exactly one cycle per computation.
- R6: Whenever `done` is 0, `sum` is driven to 0.
- R7: A `start` pulse sampled while a computation is running has no effect. The pending `done` pulse keeps its cycle and value, and no extra pulse follows.
- R8: If `start` is high on the edge that ends the done cycle, a new computation begins at once. With `start` held high, `done` pulses every 9 cycles.
- R9: `rst` takes priority over `start` and aborts a running computation. No `done` pulse follows an aborted run, and `rst` together with `start` does not begin a run.
- R10: A computation started after an aborted run yields the full total again, with nothing left over from the aborted run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, has priority over start |
| start | input | 1 | Start request, sampled on rising edges while idle or during the done cycle |
| sum | output | 16 | Accumulated total while done is high, zero otherwise |
| done | output | 1 | One-cycle completion strobe |

## Verification
`done` and `sum` both come from registers, so each result is due a fixed number of edges after its stimulus. For a start, that is the ninth output cycle after the accepting edge. For a reset, it is the cycle right after the reset edge. For a held start, it is every ninth cycle. The bench drives and samples on falling edges, counts falling edges from the one where `start` was raised, and checks `done` and `sum` on every counted cycle against the expected cycle index. In the sweeps, a stray start or a reset is injected at each offset inside a run, and the expected pulse position is recomputed for that offset.

// File: rtl/seq_rom_accum_pkg.sv
package seq_rom_accum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_e;

    // k-th smallest prime (k = 0 gives 2); valid for k up to 30
    function automatic int nth_prime(input int idx);
        int found;
        int result;
        logic is_p;
        found  = 0;
        result = 0;
        for (int c = 2; c < 128; c++) begin
            is_p = 1'b1;
            for (int d = 2; d < 12; d++) begin
                if (d < c && (c % d) == 0) is_p = 1'b0;
            end
            if (is_p && result == 0) begin
                if (found == idx) result = c;
                found++;
            end
        end
        return result;
    endfunction

    function automatic int table_total(input int depth);
        int acc;
        acc = 0;
        for (int k = 0; k < depth; k++) acc += nth_prime(k);
        return acc;
    endfunction

endpackage

// File: rtl/seq_rom_accum_rom.sv
module seq_rom_accum_rom #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]    addr,
    output logic [WIDTH-1:0] rdata
);
    import seq_rom_accum_pkg::*;

    logic [WIDTH-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign entry[g] = WIDTH'(nth_prime(g));
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (addr == AW'(k)) rdata = entry[k];
        end
    end
endmodule

// File: rtl/seq_rom_accum_ctl.sv
module seq_rom_accum_ctl #(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [AW-1:0] addr,
    output logic          acc_clr,
    output logic          acc_add,
    output logic          done
);
    import seq_rom_accum_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        ctl_state_e    st;
        logic [AW-1:0] addr;
    } ctl_reg_t;

    ctl_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        acc_clr = 1'b0;
        acc_add = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_RUN;
                    r_d.addr = '0;
                    acc_clr  = 1'b1;
                end
            end
            ST_RUN: begin
                acc_add  = 1'b1;
                r_d.addr = r_q.addr + 1'b1;
                if (r_q.addr == LAST) r_d.st = ST_DONE;
            end
            ST_DONE: begin
                if (start) begin
                    r_d.st   = ST_RUN;
                    r_d.addr = '0;
                    acc_clr  = 1'b1;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (rst) begin
            r_d.st   = ST_IDLE;
            r_d.addr = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign addr = r_q.addr;
    assign done = (r_q.st == ST_DONE);
endmodule

// File: rtl/seq_rom_accum_dp.sv
module seq_rom_accum_dp #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             acc_clr,
    input  logic             acc_add,
    input  logic             done,
    output logic [WIDTH-1:0] sum
);
    logic signed [WIDTH-1:0] operand;
    logic signed [WIDTH-1:0] acc_d, acc_q;

    seq_rom_accum_rom #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rom (
        .addr  (addr),
        .rdata (operand)
    );

    always_comb begin
        acc_d = acc_q;
        if (rst)          acc_d = '0;
        else if (acc_clr) acc_d = '0;
        else if (acc_add) acc_d = acc_q + operand;
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    assign sum = done ? acc_q : '0;
endmodule

// File: rtl/seq_rom_accum.sv
module seq_rom_accum #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [WIDTH-1:0] sum,
    output logic             done
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] addr;
    logic          acc_clr;
    logic          acc_add;

    seq_rom_accum_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .addr    (addr),
        .acc_clr (acc_clr),
        .acc_add (acc_add),
        .done    (done)
    );

    seq_rom_accum_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .acc_clr (acc_clr),
        .acc_add (acc_add),
        .done    (done),
        .sum     (sum)
    );
endmodule

// File: rtl/seq_rom_accum_chk.sv
module seq_rom_accum_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] sum,
    input logic             done
);
    import seq_rom_accum_pkg::*;

    localparam logic [WIDTH-1:0] TOTAL = WIDTH'(table_total(DEPTH));

    // independent timing model: busy window counter and expected strobe
    logic busy_m;
    int   cnt_m;
    logic fin_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_m <= 1'b0;
            cnt_m  <= 0;
            fin_m  <= 1'b0;
        end else begin
            fin_m <= 1'b0;
            if (busy_m) begin
                if (cnt_m == DEPTH - 1) begin
                    busy_m <= 1'b0;
                    fin_m  <= 1'b1;
                end else begin
                    cnt_m <= cnt_m + 1;
                end
            end else if (start) begin
                busy_m <= 1'b1;
                cnt_m  <= 0;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && sum == '0));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done == fin_m);

    // R4
    total_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> sum == TOTAL);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    sum_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> sum == '0);
endmodule

bind seq_rom_accum seq_rom_accum_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .sum   (sum),
    .done  (done)
);

// File: tb/seq_rom_accum_test.sv
module seq_rom_accum_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] sum;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] total;

    always #10 clk = ~clk;

    seq_rom_accum uut (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .sum   (sum),
        .done  (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic logic [15:0] bench_total();
        int got, acc, c;
        got = 0; acc = 0; c = 1;
        while (got < 8) begin
            bit prime;
            c++;
            prime = 1;
            for (int d = 2; d * d <= c; d++) if (c % d == 0) prime = 0;
            if (prime) begin acc += c; got++; end
        end
        return acc[15:0];
    endfunction

    // one run from idle with an optional stray start at cycle j (0 = none)
    task automatic one_run(input int j, input string req);
        start = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            start = (k == j);
            chk({req, " done"}, done, (k == 9));
            chk({req, " sum"}, sum, (k == 9) ? total : 0);
        end
        start = 1'b0;
    endtask

    initial begin
        total = bench_total();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", done, 0);
        chk("R1 sum", sum, 0);
        rst = 1'b0;

        // R2 / R6: idle without start
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R2 done", done, 0);
            chk("R6 sum", sum, 0);
        end

        // R3 / R4 / R5: plain runs with varying idle gaps
        for (int gap = 0; gap < 4; gap++) begin
            repeat (gap) @(negedge clk);
            one_run(0, "R3/R4/R5");
        end

        // R7: stray start at every running offset
        for (int j = 1; j <= 8; j++) one_run(j, "R7");

        // R8: held start -> back-to-back runs
        start = 1'b1;
        for (int k = 1; k <= 27; k++) begin
            @(negedge clk);
            if (k == 27) start = 1'b0;
            chk("R8 done", done, (k % 9 == 0));
            chk("R8 sum", sum, (k % 9 == 0) ? total : 0);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 idle", done, 0);
        end

        // R9 / R10: reset (with start) at each running offset
        for (int j = 1; j <= 8; j++) begin
            start = 1'b1;
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                rst   = (k == j);
                start = (k == j);
                chk("R9 done", done, 0);
                chk("R9 sum", sum, 0);
            end
            rst = 1'b0;
            start = 1'b0;
            one_run(0, "R10");
        end

        // R9: reset together with start from idle
        rst = 1'b1;
        start = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        start = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R9 rst+start", done, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule